// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from GPIO pins. It keeps one pending flag per source and offers a single winning vector index to the CPU. Each source has a 2-bit code that both enables it and sets its level. Code 0 masks the source, and codes 1, 2 and 3 select low, medium and high level. When several eligible sources are pending, the highest level wins. Within one level, the smaller vector index wins.

The CPU side is a valid/ready pair. `irq_valid` is the request line and `irq_vec` is the index offered with it. A transfer happens on a cycle where `irq_valid` and `irq_ready` are both high. Back-pressure is allowed: the CPU may hold `irq_ready` low for any length of time. While it waits, the offered index follows the current winner, so a newly arrived source at a higher level replaces the earlier offer. On a transfer, an ordinary source's pending flag clears in the same cycle. A source marked continuous (parameter `CONT_MASK`) stays pending until software clears it.

Software can also poll. It reads the pending register and clears flags by writing ones to it, and the CPU request path plays no part in this. A master enable gates the request line and leaves the pending flags as they are. The upper `N_GPIO` sources are GPIO pins. Each pin passes through a two-flop synchronizer and is then compared with its previous synchronized value. A per-pin rising enable and falling enable together choose rising, falling or both edges.

Top module: `intc_prio3`

## Requirements
- R1: After reset, every pending flag, level code, edge enable and the master enable read 0, and `irq_valid` is low.
- R2: A source with code 0 can become pending and reads back as pending at register address 0, but it never drives `irq_valid`.
- R3: With the master enable set, `irq_valid` is high whenever some pending source has a nonzero code. `irq_vec` then names a source of the highest code among those. A source's code is {bit i of address 2, bit i of address 1}.
- R4: Among eligible pending sources sharing the highest code, `irq_vec` is the lowest index.
- R5: A transfer (`irq_valid` and `irq_ready` high) clears the pending flag of an ordinary source at that clock edge.
- R6: A transfer leaves the pending flag of a continuous source set. Only a software clear removes it.
- R7: GPIO pin j maps to source N_SRC-N_GPIO+j. Bit j of address 3 enables its rising edge and bit j of address 4 enables its falling edge. An enabled edge on the pin sets the pending flag at the third rising clock edge after the pin changes.
- R8: Address 5 bit 0 is the master enable. When it is 0, `irq_valid` stays low and the pending flags are unchanged.
- R9: If a new event for a source arrives in the same cycle as its clear (software or transfer), the flag ends up set.
- R10: Writing to address 0 clears each pending flag whose data bit is 1 and leaves the others alone. Unused addresses 6 and 7 read 0.
- R11: Peripheral source i (i < N_SRC-N_GPIO) becomes pending at every clock edge where `periph_req[i]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req | input | N_SRC-N_GPIO | Peripheral request levels |
| gpio_pin | input | N_GPIO | Asynchronous GPIO pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | N_SRC | Register write data |
| reg_rdata | output | N_SRC | Register read data for `reg_addr` |
| irq_valid | output | 1 | Interrupt request to the CPU |
| irq_ready | input | 1 | CPU takes the offered vector |
| irq_vec | output | VW | Winning vector index |

## Verification
Two functions can land on the same flag in one cycle: a new event (a peripheral request level or a GPIO edge) and a clear (a software write to address 0, or a transfer). The bench provokes this by holding a peripheral request high during the cycle that acknowledges the same source, and by writing the clear for a source while its request is high. The expected result is that the flag stays set, and the bench confirms this by reading address 0. A cycle-level reference model predicts `irq_valid`, `irq_vec` and the read data on every clock, so any cycle where a set and a clear meet is judged against an independent prediction.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [1:0] prio_t;

  localparam prio_t PRIO_OFF  = 2'd0;
  localparam prio_t PRIO_LOW  = 2'd1;
  localparam prio_t PRIO_MID  = 2'd2;
  localparam prio_t PRIO_HIGH = 2'd3;

  typedef enum logic [2:0] {
    RA_PEND   = 3'd0,
    RA_LVL_A  = 3'd1,
    RA_LVL_B  = 3'd2,
    RA_RISE   = 3'd3,
    RA_FALL   = 3'd4,
    RA_CTRL   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] evt
);
  for (genvar j = 0; j < W; j++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin[j];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign evt[j] = (rise_en[j] &  sync_q & ~prev_q)
                  | (fall_en[j] & ~sync_q &  prev_q);
  end
endmodule

// File: rtl/intc_pend_bank.sv
module intc_pend_bank #(
  parameter int          N         = 24,
  parameter logic [N-1:0] CONT_MASK = '0,
  localparam int         VW        = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_evt,
  input  logic [N-1:0]  sw_clr,
  input  logic          ack_fire,
  input  logic [VW-1:0] ack_vec,
  output logic [N-1:0]  pend
);
  logic [N-1:0] ack_clr;

  always_comb begin
    ack_clr = '0;
    for (int i = 0; i < N; i++) begin
      if (ack_fire && (ack_vec == VW'(i)) && !CONT_MASK[i]) ack_clr[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~(sw_clr | ack_clr)) | set_evt;
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N  = 24,
  localparam int VW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  lvl_a,
  input  logic [N-1:0]  lvl_b,
  output logic          hit,
  output logic [VW-1:0] vec
);
  logic [N-1:0]  lvl_mask [1:3];
  logic [3:1]    lvl_hit;
  logic [VW-1:0] lvl_vec  [1:3];

  for (genvar lv = 1; lv <= 3; lv++) begin : g_lvl
    always_comb begin
      for (int i = 0; i < N; i++) begin
        lvl_mask[lv][i] = pend[i] && ({lvl_b[i], lvl_a[i]} == prio_t'(lv));
      end
    end
    always_comb begin
      lvl_hit[lv] = 1'b0;
      lvl_vec[lv] = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (lvl_mask[lv][i]) begin
          lvl_hit[lv] = 1'b1;
          lvl_vec[lv] = VW'(i);
        end
      end
    end
  end

  always_comb begin
    hit = |lvl_hit;
    if (lvl_hit[3])      vec = lvl_vec[3];
    else if (lvl_hit[2]) vec = lvl_vec[2];
    else                 vec = lvl_vec[1];
  end
endmodule

// File: rtl/intc_prio3.sv
module intc_prio3
  import intc_pkg::*;
#(
  parameter int                N_SRC     = 24,
  parameter int                N_GPIO    = 8,
  parameter logic [N_SRC-1:0]  CONT_MASK = 24'h000030,
  localparam int               N_PER     = N_SRC - N_GPIO,
  localparam int               VW        = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PER-1:0] periph_req,
  input  logic [N_GPIO-1:0] gpio_pin,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [VW-1:0]    irq_vec
);
  logic [N_SRC-1:0]  lvl_a, lvl_b, pend, set_evt, sw_clr;
  logic [N_GPIO-1:0] rise_en, fall_en, gpio_evt;
  logic              master, hit, ack_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_a   <= '0;
      lvl_b   <= '0;
      rise_en <= '0;
      fall_en <= '0;
      master  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_LVL_A: lvl_a   <= reg_wdata;
        RA_LVL_B: lvl_b   <= reg_wdata;
        RA_RISE:  rise_en <= reg_wdata[N_GPIO-1:0];
        RA_FALL:  fall_en <= reg_wdata[N_GPIO-1:0];
        RA_CTRL:  master  <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_PEND:  reg_rdata = pend;
      RA_LVL_A: reg_rdata = lvl_a;
      RA_LVL_B: reg_rdata = lvl_b;
      RA_RISE:  reg_rdata = N_SRC'(rise_en);
      RA_FALL:  reg_rdata = N_SRC'(fall_en);
      RA_CTRL:  reg_rdata = N_SRC'(master);
      default:  reg_rdata = '0;
    endcase
  end

  assign sw_clr  = (reg_wr && reg_addr == RA_PEND) ? reg_wdata : '0;
  assign set_evt = {gpio_evt, periph_req};

  intc_edge_sync #(.W(N_GPIO)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(gpio_pin),
    .rise_en(rise_en), .fall_en(fall_en), .evt(gpio_evt)
  );

  intc_arbiter #(.N(N_SRC)) u_arb (
    .pend(pend), .lvl_a(lvl_a), .lvl_b(lvl_b), .hit(hit), .vec(irq_vec)
  );

  assign irq_valid = master & hit;
  assign ack_fire  = irq_valid & irq_ready;

  intc_pend_bank #(.N(N_SRC), .CONT_MASK(CONT_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .sw_clr(sw_clr),
    .ack_fire(ack_fire), .ack_vec(irq_vec), .pend(pend)
  );
endmodule

// File: rtl/intc_prio3_chk.sv
module intc_prio3_chk #(
  parameter int               N_SRC     = 24,
  parameter logic [N_SRC-1:0] CONT_MASK = '0,
  localparam int              VW        = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [VW-1:0]    irq_vec,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] lvl_a,
  input logic [N_SRC-1:0] lvl_b,
  input logic [N_SRC-1:0] set_evt,
  input logic [N_SRC-1:0] sw_clr,
  input logic             master
);
  logic [1:0] top_lvl, vec_lvl;
  logic       lower_tie;
  logic       fire;

  assign fire    = irq_valid && irq_ready;
  assign vec_lvl = {lvl_b[irq_vec], lvl_a[irq_vec]};

  always_comb begin
    top_lvl   = 2'd0;
    lower_tie = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && {lvl_b[i], lvl_a[i]} > top_lvl) top_lvl = {lvl_b[i], lvl_a[i]};
    end
    for (int i = 0; i < N_SRC; i++) begin
      if (VW'(i) < irq_vec && pend[i] && {lvl_b[i], lvl_a[i]} == top_lvl) lower_tie = 1'b1;
    end
  end

  assert_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pend[irq_vec] && vec_lvl != 2'd0));

  assert_top_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (vec_lvl == top_lvl));

  assert_low_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !lower_tie);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !CONT_MASK[irq_vec] && !set_evt[irq_vec]) |=> !pend[$past(irq_vec)]);

  assert_cont_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && CONT_MASK[irq_vec] && !sw_clr[irq_vec]) |=> pend[$past(irq_vec)]);

  assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !irq_valid);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_evt) |=> ((pend & $past(set_evt)) == $past(set_evt)));
endmodule

bind intc_prio3 intc_prio3_chk #(.N_SRC(N_SRC), .CONT_MASK(CONT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_vec(irq_vec), .pend(pend), .lvl_a(lvl_a), .lvl_b(lvl_b),
  .set_evt(set_evt), .sw_clr(sw_clr), .master(master)
);

// File: tb/sim_intc_prio3.sv
`timescale 1ns/1ps
module sim_intc_prio3;
  localparam int N = 24, NG = 8, NP = 16;
  localparam logic [23:0] CONT = 24'h000030;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] periph_req = '0;
  logic [NG-1:0] gpio_pin = '0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic irq_valid, irq_ready = 0;
  logic [4:0] irq_vec;

  int checks = 0, failures = 0;
  string cur = "R1";

  always #5 clk = ~clk;

  intc_prio3 u0 (.*);

  // behavioural reference model
  logic [23:0] m_pend, m_la, m_lb;
  logic [7:0]  m_rise, m_fall, h1, h2, h3;
  logic        m_master;

  function automatic void m_win(output bit found, output int v);
    found = 0; v = 0;
    for (int lv = 3; lv >= 1 && !found; lv--)
      for (int i = 0; i < N && !found; i++)
        if (m_pend[i] && int'({m_lb[i], m_la[i]}) == lv) begin found = 1; v = i; end
  endfunction

  function automatic logic [23:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_pend;
      3'd1: return m_la;
      3'd2: return m_lb;
      3'd3: return {16'h0, m_rise};
      3'd4: return {16'h0, m_fall};
      3'd5: return {23'h0, m_master};
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_la = '0; m_lb = '0; m_rise = '0; m_fall = '0;
      m_master = 0; h1 = '0; h2 = '0; h3 = '0;
    end else begin
      bit f; int v; logic [23:0] evt, clr;
      m_win(f, v);
      evt = {8'h0, periph_req};
      for (int j = 0; j < NG; j++)
        if ((m_rise[j] && h2[j] && !h3[j]) || (m_fall[j] && !h2[j] && h3[j])) evt[NP+j] = 1;
      clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata : '0;
      if (m_master && f && irq_ready && !CONT[v]) clr[v] = 1;
      m_pend = (m_pend & ~clr) | evt;
      if (reg_wr) case (reg_addr)
        3'd1: m_la = reg_wdata;
        3'd2: m_lb = reg_wdata;
        3'd3: m_rise = reg_wdata[7:0];
        3'd4: m_fall = reg_wdata[7:0];
        3'd5: m_master = reg_wdata[0];
        default: ;
      endcase
      h3 = h2; h2 = h1; h1 = gpio_pin;
    end
  end

  task automatic chk(string r, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", r, what, act, exp, $time);
    end
  endtask

  // cycle compare against model, away from the active edge
  always @(negedge clk) if (rst_n) begin
    bit f; int v;
    m_win(f, v);
    chk(cur, irq_valid, f && m_master, "irq_valid");
    if (f && m_master) chk(cur, irq_vec, v, "irq_vec");
    chk(cur, reg_rdata, m_read(reg_addr), "reg_rdata");
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [23:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd_expect(string r, logic [2:0] a, logic [23:0] e);
    reg_addr = a; #1; chk(r, reg_rdata, e, "read");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(2);
    // R1 reset state
    cur = "R1";
    for (int a = 0; a < 6; a++) rd_expect("R1", 3'(a), 24'h0);
    chk("R1", irq_valid, 0, "irq_valid after reset");

    // R2 disabled source still pending, no request
    cur = "R2";
    wr(3'd5, 24'h1);
    periph_req[3] = 1; tick(); periph_req = '0;
    rd_expect("R2", 3'd0, 24'h000008);
    tick(2);
    chk("R2", irq_valid, 0, "masked source");

    // R10 write-one-to-clear, unused addresses
    cur = "R10";
    wr(3'd0, 24'h000008);
    rd_expect("R10", 3'd0, 24'h0);
    rd_expect("R10", 3'd6, 24'h0);
    rd_expect("R10", 3'd7, 24'h0);

    // R3 higher level beats lower index
    cur = "R3";
    wr(3'd1, 24'h001400);            // src10 code1, src12 code3
    wr(3'd2, 24'h001000);
    periph_req[10] = 1; periph_req[12] = 1; tick(); periph_req = '0;
    chk("R3", irq_vec, 12, "high level wins");
    tick(3);

    // R5 acknowledge clears ordinary source
    cur = "R5";
    irq_ready = 1; tick(); irq_ready = 0;
    rd_expect("R5", 3'd0, 24'h000400);
    chk("R5", irq_vec, 10, "next winner");
    irq_ready = 1; tick(); irq_ready = 0;
    rd_expect("R5", 3'd0, 24'h0);

    // R4 tie within level
    cur = "R4";
    wr(3'd1, 24'h0); wr(3'd2, 24'h000082);   // src1, src7 code2
    periph_req[7] = 1; tick(); periph_req[1] = 1; tick(); periph_req = '0;
    chk("R4", irq_vec, 1, "lowest index");
    irq_ready = 1; tick(2); irq_ready = 0;
    rd_expect("R4", 3'd0, 24'h0);

    // R6 continuous source survives acknowledge
    cur = "R6";
    wr(3'd1, 24'h000010); wr(3'd2, 24'h000010);   // src4 code3
    periph_req[4] = 1; tick(); periph_req = '0;
    irq_ready = 1; tick(3); irq_ready = 0;
    rd_expect("R6", 3'd0, 24'h000010);
    chk("R6", irq_valid, 1, "still requesting");
    wr(3'd0, 24'h000010);
    rd_expect("R6", 3'd0, 24'h0);

    // R8 master enable gates without clearing
    cur = "R8";
    periph_req[4] = 1; tick(); periph_req = '0;
    wr(3'd5, 24'h0); tick(2);
    chk("R8", irq_valid, 0, "gated");
    rd_expect("R8", 3'd0, 24'h000010);
    wr(3'd5, 24'h1);
    chk("R8", irq_valid, 1, "reenabled");
    wr(3'd0, 24'h000010);

    // R9 set wins over software clear and over acknowledge
    cur = "R9";
    wr(3'd1, 24'h000001); wr(3'd2, 24'h0);    // src0 code1
    periph_req[0] = 1; tick();
    reg_wr = 1; reg_addr = 3'd0; reg_wdata = 24'h000001; tick(); reg_wr = 0;
    rd_expect("R9", 3'd0, 24'h000001);
    irq_ready = 1; tick(); irq_ready = 0; periph_req = '0;
    rd_expect("R9", 3'd0, 24'h000001);

    // R11 level request re-pends each cycle
    cur = "R11";
    irq_ready = 1; tick(); irq_ready = 0;
    rd_expect("R11", 3'd0, 24'h0);
    periph_req[2] = 1; tick(4); periph_req = '0;
    rd_expect("R11", 3'd0, 24'h000004);
    wr(3'd0, 24'h000004);

    // R7 GPIO edges: pin0 rise, pin1 fall, pin2 both
    cur = "R7";
    wr(3'd3, 24'h05); wr(3'd4, 24'h06);
    wr(3'd1, 24'h070000); wr(3'd2, 24'h070000);
    gpio_pin = 8'h07; tick(2);
    rd_expect("R7", 3'd0, 24'h0);
    tick();
    rd_expect("R7", 3'd0, 24'h050000);
    wr(3'd0, 24'hFF0000); tick(2);
    gpio_pin = 8'h00; tick(3);
    rd_expect("R7", 3'd0, 24'h060000);
    chk("R7", irq_vec, 17, "gpio winner");
    wr(3'd0, 24'hFF0000);
    gpio_pin = 8'h08; tick(5);                 // pin3 not enabled
    rd_expect("R7", 3'd0, 24'h0);

    tick(3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule